// File: doc/BRIEF.md
# Time-of-Day Counter with Pulse-per-Second Output

This block keeps wall-clock time for a timing subsystem. It holds a seconds count and a nanoseconds value with a 32-bit binary fraction. On every reference clock cycle it adds a host-programmed step, written in 32.32 fixed-point nanoseconds. The nominal step is (10^9 << 32) divided by the reference frequency in Hz. Software trims the frequency by rewriting the step: a larger value makes time run faster and a smaller value makes it run slower.

When the integer nanoseconds reach one billion, the block takes exactly 10^9 away from the full fixed-point value. It keeps whatever is left over and adds one to the seconds. Because the overshoot is kept, no error builds up across second boundaries.

A second accumulator advances by the same step and drives a square-wave timing output. The output has separately programmed high and low interval lengths, in the same 32.32 nanosecond format. A rising edge on the event input captures seconds and nanoseconds together. Reading the nanoseconds register freezes a copy of the seconds, so that a following seconds read matches it.

Top module: `tod_counter`

## Requirements
- R1: Synchronous reset clears the step, both pulse intervals, the time, both capture registers, the seconds snapshot and the read data. While the step is zero, the time does not advance.
- R2: The step register (address 0, 64 bits: integer nanoseconds in [63:32], fraction in [31:0]) is added to the time on every cycle. Carries out of the fraction advance the integer nanoseconds.
- R3: A written step is first used on the clock edge after the write edge. Rewriting the step keeps the current time and fraction.
- R4: The integer nanoseconds never reach 1,000,000,000. The value 999,999,999 is held without a rollover.
- R5: When a sum reaches 10^9 integer nanoseconds, 10^9 << 32 is subtracted from the full fixed-point sum. The remainder, integer and fraction, is kept, and the seconds count goes up by exactly one.
- R6: Reading address 1 returns the integer nanoseconds in [31:0] and copies the seconds into a snapshot. Reading address 2 returns that snapshot.
- R7: A low-to-high change on `evt_in` captures the nanoseconds and seconds of that edge together (address 5 and address 6). Holding `evt_in` high does not capture again.
- R8: The pulse output starts in its low phase. Each phase ends once the accumulated step reaches that phase's interval: address 4 for the low phase, address 3 for the high phase. The overshoot carries into the next phase.
- R9: From reset until a nonzero step is first used, `pps_out` stays low.
- R10: A read presents its data on `rdata` one cycle after `rd_en`, taken from the state before that edge, and holds it until the next read. Address 7 reads as zero. Addresses 0, 3 and 4 read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Registered read data |
| evt_in | input | 1 | Event input, captured on its rising edge |
| pps_out | output | 1 | Programmable pulse output |

## Verification
A wrong step, fraction or pulse-accumulator value shows on `pps_out` within one phase, and a reference model compares that output on every cycle. A bad rollover shows up on the first nanoseconds or seconds read after the boundary. That read returns either a value of at least 10^9, a lost remainder, or seconds out of step with the model. Directed cases pin the exact wrap, the 999,999,999 hold, a half-nanosecond remainder and a mid-run step change to literal values within a few cycles.

// File: rtl/tod_pkg.sv
package tod_pkg;
   typedef enum logic [2:0] {
      ADR_STEP    = 3'd0,
      ADR_NSEC    = 3'd1,
      ADR_SEC     = 3'd2,
      ADR_PPS_HI  = 3'd3,
      ADR_PPS_LO  = 3'd4,
      ADR_CAP_NS  = 3'd5,
      ADR_CAP_SEC = 3'd6,
      ADR_NONE    = 3'd7
   } tod_addr_e;
endpackage

// File: rtl/tod_accum.sv
module tod_accum #(
   parameter int unsigned     NS_W     = 32,
   parameter int unsigned     FRAC_W   = 32,
   parameter int unsigned     SEC_W    = 48,
   parameter longint unsigned NS_LIMIT = 64'd1_000_000_000
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NS_W+FRAC_W-1:0]   step,
   output logic [NS_W-1:0]          ns_q,
   output logic [FRAC_W-1:0]        frac_q,
   output logic [SEC_W-1:0]         sec_q
);
   localparam int unsigned ACC_W = NS_W + FRAC_W;
   localparam logic [ACC_W:0] LIMIT_FX = (ACC_W+1)'(NS_LIMIT) << FRAC_W;

   logic [ACC_W:0] sum;
   logic [ACC_W:0] nxt;
   logic           wrap;

   // Full fixed-point sum; remainder is kept on wrap.
   always_comb begin
      sum  = {1'b0, ns_q, frac_q} + {1'b0, step};
      wrap = (sum >= LIMIT_FX);
      nxt  = wrap ? (sum - LIMIT_FX) : sum;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ns_q   <= '0;
         frac_q <= '0;
         sec_q  <= '0;
      end else begin
         {ns_q, frac_q} <= nxt[ACC_W-1:0];
         if (wrap) sec_q <= sec_q + SEC_W'(1);
      end
   end
endmodule

// File: rtl/tod_pps.sv
module tod_pps #(
   parameter int unsigned ACC_W = 64
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ACC_W-1:0] step,
   input  logic [ACC_W-1:0] hi_len,
   input  logic [ACC_W-1:0] lo_len,
   output logic             level_q
);
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W:0]   sum;
   logic [ACC_W:0]   lim;
   logic [ACC_W:0]   nxt;
   logic             flip;

   always_comb begin
      sum  = {1'b0, acc_q} + {1'b0, step};
      lim  = level_q ? {1'b0, hi_len} : {1'b0, lo_len};
      flip = (sum >= lim);
      nxt  = flip ? (sum - lim) : sum;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q   <= '0;
         level_q <= 1'b0;
      end else if (step != '0) begin
         acc_q <= nxt[ACC_W-1:0];
         if (flip) level_q <= ~level_q;
      end
   end
endmodule

// File: rtl/tod_regs.sv
module tod_regs
   import tod_pkg::*;
#(
   parameter int unsigned NS_W   = 32,
   parameter int unsigned FRAC_W = 32,
   parameter int unsigned SEC_W  = 48
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  logic [2:0]               addr,
   input  logic [NS_W+FRAC_W-1:0]   wdata,
   input  logic [NS_W-1:0]          ns,
   input  logic [SEC_W-1:0]         sec,
   input  logic                     evt_in,
   output logic [NS_W+FRAC_W-1:0]   step_q,
   output logic [NS_W+FRAC_W-1:0]   hi_q,
   output logic [NS_W+FRAC_W-1:0]   lo_q,
   output logic [NS_W-1:0]          cap_ns_q,
   output logic [SEC_W-1:0]         cap_sec_q,
   output logic [NS_W+FRAC_W-1:0]   rdata_q
);
   localparam int unsigned ACC_W = NS_W + FRAC_W;

   logic             evt_q;
   logic             evt_rise;
   logic [SEC_W-1:0] snap_q;
   logic [ACC_W-1:0] rd_mux;
   tod_addr_e        sel;

   always_ff @(posedge clk) evt_q <= evt_in;
   assign evt_rise = evt_in & ~evt_q;
   assign sel      = tod_addr_e'(addr);

   always_comb begin
      case (sel)
         ADR_STEP:    rd_mux = step_q;
         ADR_NSEC:    rd_mux = ACC_W'(ns);
         ADR_SEC:     rd_mux = ACC_W'(snap_q);
         ADR_PPS_HI:  rd_mux = hi_q;
         ADR_PPS_LO:  rd_mux = lo_q;
         ADR_CAP_NS:  rd_mux = ACC_W'(cap_ns_q);
         ADR_CAP_SEC: rd_mux = ACC_W'(cap_sec_q);
         default:     rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         step_q    <= '0;
         hi_q      <= '0;
         lo_q      <= '0;
         cap_ns_q  <= '0;
         cap_sec_q <= '0;
         snap_q    <= '0;
         rdata_q   <= '0;
      end else begin
         if (wr_en) begin
            case (sel)
               ADR_STEP:   step_q <= wdata;
               ADR_PPS_HI: hi_q   <= wdata;
               ADR_PPS_LO: lo_q   <= wdata;
               default:    ;
            endcase
         end
         if (evt_rise) begin
            cap_ns_q  <= ns;
            cap_sec_q <= sec;
         end
         if (rd_en) begin
            rdata_q <= rd_mux;
            if (sel == ADR_NSEC) snap_q <= sec;
         end
      end
   end
endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
   parameter int unsigned     NS_W     = 32,
   parameter int unsigned     FRAC_W   = 32,
   parameter int unsigned     SEC_W    = 48,
   parameter longint unsigned NS_LIMIT = 64'd1_000_000_000,
   parameter bit              PPS_EN   = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   wr_en,
   input  logic                   rd_en,
   input  logic [2:0]             addr,
   input  logic [NS_W+FRAC_W-1:0] wdata,
   output logic [NS_W+FRAC_W-1:0] rdata,
   input  logic                   evt_in,
   output logic                   pps_out
);
   localparam int unsigned ACC_W = NS_W + FRAC_W;

   if (NS_W < 30 || NS_W > 40) begin : g_bad_ns_w
      $error("tod_counter: NS_W out of range");
   end
   if (FRAC_W < 8 || FRAC_W > 32) begin : g_bad_frac_w
      $error("tod_counter: FRAC_W out of range");
   end
   if (SEC_W < 1 || SEC_W >= ACC_W) begin : g_bad_sec_w
      $error("tod_counter: SEC_W out of range");
   end
   if (NS_LIMIT == 0 || NS_LIMIT >= (64'd1 << NS_W)) begin : g_bad_limit
      $error("tod_counter: NS_LIMIT does not fit NS_W");
   end

   logic [ACC_W-1:0]  step_q;
   logic [ACC_W-1:0]  hi_q;
   logic [ACC_W-1:0]  lo_q;
   logic [NS_W-1:0]   ns_q;
   logic [FRAC_W-1:0] frac_q;
   logic [SEC_W-1:0]  sec_q;
   logic [NS_W-1:0]   cap_ns_q;
   logic [SEC_W-1:0]  cap_sec_q;

   tod_regs #(.NS_W(NS_W), .FRAC_W(FRAC_W), .SEC_W(SEC_W)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .addr      (addr),
      .wdata     (wdata),
      .ns        (ns_q),
      .sec       (sec_q),
      .evt_in    (evt_in),
      .step_q    (step_q),
      .hi_q      (hi_q),
      .lo_q      (lo_q),
      .cap_ns_q  (cap_ns_q),
      .cap_sec_q (cap_sec_q),
      .rdata_q   (rdata)
   );

   tod_accum #(.NS_W(NS_W), .FRAC_W(FRAC_W), .SEC_W(SEC_W), .NS_LIMIT(NS_LIMIT)) u_accum (
      .clk    (clk),
      .rst    (rst),
      .step   (step_q),
      .ns_q   (ns_q),
      .frac_q (frac_q),
      .sec_q  (sec_q)
   );

   if (PPS_EN) begin : g_pps
      tod_pps #(.ACC_W(ACC_W)) u_pps (
         .clk     (clk),
         .rst     (rst),
         .step    (step_q),
         .hi_len  (hi_q),
         .lo_len  (lo_q),
         .level_q (pps_out)
      );
   end else begin : g_no_pps
      assign pps_out = 1'b0;
   end
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
   parameter int unsigned     NS_W     = 32,
   parameter int unsigned     SEC_W    = 48,
   parameter int unsigned     ACC_W    = 64,
   parameter longint unsigned NS_LIMIT = 64'd1_000_000_000
) (
   input logic             clk,
   input logic             rst,
   input logic [ACC_W-1:0] step,
   input logic [NS_W-1:0]  ns,
   input logic [SEC_W-1:0] sec,
   input logic [NS_W-1:0]  cap_ns,
   input logic [SEC_W-1:0] cap_sec,
   input logic             evt_in,
   input logic             pps_out
);
   logic started_q;
   always_ff @(posedge clk) begin
      if (rst) started_q <= 1'b0;
      else if (step != '0) started_q <= 1'b1;
   end

   a_r4_ns_in_range: assert property (@(posedge clk) disable iff (rst)
      64'(ns) < NS_LIMIT);

   a_r5_sec_single_step: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (sec == $past(sec)) || (sec == $past(sec) + SEC_W'(1)));

   a_r5_wrap_adds_second: assert property (@(posedge clk) disable iff (rst)
      (ns < $past(ns)) |-> (sec == $past(sec) + SEC_W'(1)));

   a_r7_capture_pair: assert property (@(posedge clk) disable iff (rst)
      $rose(evt_in) |=> (cap_ns == $past(ns)) && (cap_sec == $past(sec)));

   a_r9_pps_idle_low: assert property (@(posedge clk) disable iff (rst)
      !started_q |-> !pps_out);
endmodule

bind tod_counter tod_counter_chk #(
   .NS_W(NS_W), .SEC_W(SEC_W), .ACC_W(NS_W + FRAC_W), .NS_LIMIT(NS_LIMIT)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .step    (step_q),
   .ns      (ns_q),
   .sec     (sec_q),
   .cap_ns  (cap_ns_q),
   .cap_sec (cap_sec_q),
   .evt_in  (evt_in),
   .pps_out (pps_out)
);

// File: tb/test_tod_counter.sv
module test_tod_counter;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [63:0] wdata = '0;
   logic [63:0] rdata;
   logic        evt_in = 1'b0;
   logic        pps_out;

   int checks = 0;
   int errors = 0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tod_counter i_tod_counter (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .pps_out(pps_out)
   );

   localparam longint unsigned LIM = 64'd1_000_000_000 << 32;

   // Behavioural reference model
   longint unsigned m_acc, m_sec, m_step, m_hi, m_lo, m_pacc;
   longint unsigned m_capns, m_capsec, m_snap, m_rdata, m_s, m_lim;
   bit m_pps, m_evt_q;

   initial begin
      m_acc = 0; m_sec = 0; m_step = 0; m_hi = 0; m_lo = 0; m_pacc = 0;
      m_capns = 0; m_capsec = 0; m_snap = 0; m_rdata = 0; m_pps = 0; m_evt_q = 0;
   end

   always @(posedge clk) begin
      if (rst) begin
         m_acc = 0; m_sec = 0; m_step = 0; m_hi = 0; m_lo = 0; m_pacc = 0;
         m_capns = 0; m_capsec = 0; m_snap = 0; m_rdata = 0; m_pps = 0;
      end else begin
         if (rd_en) begin
            case (addr)
               3'd0: m_rdata = m_step;
               3'd1: m_rdata = m_acc >> 32;
               3'd2: m_rdata = m_snap;
               3'd3: m_rdata = m_hi;
               3'd4: m_rdata = m_lo;
               3'd5: m_rdata = m_capns;
               3'd6: m_rdata = m_capsec;
               default: m_rdata = 0;
            endcase
            if (addr == 3'd1) m_snap = m_sec;
         end
         if (evt_in && !m_evt_q) begin
            m_capns = m_acc >> 32;
            m_capsec = m_sec;
         end
         m_s = m_acc + m_step;
         if (m_s >= LIM) begin m_acc = m_s - LIM; m_sec = m_sec + 1; end
         else m_acc = m_s;
         if (m_step != 0) begin
            m_lim = m_pps ? m_hi : m_lo;
            m_s = m_pacc + m_step;
            if (m_s >= m_lim) begin m_pacc = m_s - m_lim; m_pps = !m_pps; end
            else m_pacc = m_s;
         end
         if (wr_en) begin
            case (addr)
               3'd0: m_step = wdata;
               3'd3: m_hi = wdata;
               3'd4: m_lo = wdata;
               default: ;
            endcase
         end
      end
      m_evt_q = evt_in;
   end

   task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_on && !rst) begin
         check("R8 pps", 64'(pps_out), 64'(m_pps));
         check("R10 rdata", rdata, m_rdata);
      end
   end

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [63:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output longint unsigned v);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      v = rdata;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      longint unsigned v;
      int highs;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      cmp_on = 1'b1;

      // R1 / R9: reset state and idle while step is zero
      rd(3'd1, v); check("R1 ns after reset", v, 0);
      rd(3'd2, v); check("R1 sec after reset", v, 0);
      rd(3'd0, v); check("R1 step after reset", v, 0);
      wr(3'd3, 64'd7 << 32);
      repeat (20) @(negedge clk);
      check("R9 pps idle", 64'(pps_out), 0);
      rd(3'd1, v); check("R1 frozen time", v, 0);
      rd(3'd7, v); check("R10 unused address", v, 0);
      rd(3'd3, v); check("R10 readback", v, 64'd7 << 32);

      // R4 / R5: exact wrap at one billion
      do_reset();
      wr(3'd0, 64'd250_000_000 << 32);
      repeat (4) @(negedge clk);
      rd(3'd1, v); check("R4 exact wrap ns", v, 0);
      rd(3'd2, v); check("R6 snapshot sec", v, 1);

      // R4: 999,999,999 is held
      do_reset();
      wr(3'd0, 64'd333_333_333 << 32);
      repeat (3) @(negedge clk);
      rd(3'd1, v); check("R4 no early wrap ns", v, 64'd999_999_999);
      rd(3'd2, v); check("R4 no early wrap sec", v, 0);

      // R5: remainder kept
      do_reset();
      wr(3'd0, (64'd300_000_000 << 32) | 64'h8000_0000);
      repeat (4) @(negedge clk);
      rd(3'd1, v); check("R5 remainder ns", v, 64'd200_000_002);
      rd(3'd2, v); check("R5 seconds", v, 1);

      // R2: fraction carries
      do_reset();
      wr(3'd0, 64'h8000_0000);
      repeat (7) @(negedge clk);
      rd(3'd1, v); check("R2 fraction carry", v, 3);

      // R3: step change timing, R7 capture
      do_reset();
      wr(3'd0, 64'd10 << 32);
      repeat (2) @(negedge clk);
      wr(3'd0, 64'd100 << 32);
      rd(3'd1, v); check("R3 old step on write edge", v, 30);
      rd(3'd1, v); check("R3 new step next edge", v, 130);
      evt_in = 1'b1;
      repeat (4) @(negedge clk);
      evt_in = 1'b0;
      rd(3'd5, v); check("R7 capture ns", v, 230);
      rd(3'd6, v); check("R7 capture sec", v, 0);

      // R8: pulse phases
      do_reset();
      wr(3'd3, 64'd3 << 32);
      wr(3'd4, 64'd5 << 32);
      wr(3'd0, 64'd1 << 32);
      repeat (4) @(negedge clk);
      check("R8 low phase first", 64'(pps_out), 0);
      @(negedge clk);
      check("R8 high after low interval", 64'(pps_out), 1);
      highs = 0;
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         if (pps_out) highs++;
      end
      check("R8 duty over 80 cycles", 64'(highs), 30);

      // Mixed traffic compared against the model (R2 R5 R6 R7 R8 R10)
      do_reset();
      wr(3'd3, 64'd1_500_000_000 << 32);
      wr(3'd4, 64'd2_000_000_000 << 32);
      for (int k = 0; k < 400; k++) begin
         if (k % 37 == 0)
            wr(3'd0, (64'($urandom_range(900_000_000, 1)) << 32) | 64'($urandom));
         else if (k % 5 == 0) begin
            rd(3'd1, v); check("R6 ns read", v, m_rdata);
            rd(3'd2, v); check("R6 sec read", v, m_rdata);
         end else if (k % 11 == 0) begin
            evt_in = ~evt_in;
            @(negedge clk);
         end else if (k % 13 == 0) begin
            rd(3'd5, v); check("R7 cap ns read", v, m_rdata);
            rd(3'd6, v); check("R7 cap sec read", v, m_rdata);
         end else
            @(negedge clk);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule